// File: doc/BRIEF.md
# Hardware Ready-Queue Task Scheduler

This block holds the set of tasks that are ready to run, kept in priority order in on-chip storage, and always presents the task that should receive the processor next. Software or a neighbouring controller issues commands over a valid/ready port. Each command carries an opcode, a 32-bit task handle and, for insertion, an ordering key such as a priority level or a deadline. A smaller key means a more urgent task.

Inside the block, each 32-bit handle is bound to a slot whose index is only as wide as the design-time task limit needs. The ordered list, its links and its search logic all work on these narrow indices. An insertion walks the list from the head, one entry per clock, to find its place. A removal walks the list the same way to find the predecessor it must unlink from. When relative keys are enabled, each list entry stores only how far its key lies beyond the key of the entry before it. The head entry stores its full key. A task can be parked by a suspend command and later put back by a resume command. Parking keeps its handle binding and remembers its full key.

Top module: `rq_sched`

## Requirements
- R1: After reset the queue is empty: `head_valid`=0, `busy`=0, `err`=0 and `cmd_ready`=1.
- R2: An accepted insert (opcode 0) of an unbound handle binds it to a free slot and links it in ascending key order. When the command completes, `head_handle`/`head_key` show the task with the smallest key.
- R3: A task inserted or resumed with a key equal to keys already queued is placed after all of them, which gives first-in-first-out order among ties.
- R4: Remove (opcode 1) takes a bound task out of the queue and releases its binding, so the same handle can later be inserted again. The next task in order becomes head with its own full key.
- R5: Suspend (opcode 2) takes a queued task out of the order but keeps its binding. Resume (opcode 3) of a suspended task links it back in using the key it had when it was suspended.
- R6: Remove, suspend or resume naming an unbound handle, and insert naming an already bound handle, set `err` to 1 and leave the queue unchanged.
- R7: An insert while all MAX_TASKS slots are bound sets `err` to 1 and leaves the queue unchanged. Both queued and suspended tasks hold a slot.
- R8: `err` reflects the latest accepted command. It is cleared by any accepted command that is not in error.
- R9: `busy` is high from the cycle after a list-walking command is accepted until that command completes, and `cmd_ready` equals the inverse of `busy`. A walk lasts at most MAX_TASKS+1 cycles.
- R10: Suspending an already suspended task, or resuming a task that is already queued, changes nothing and leaves `err` at 0.
- R11: With relative keys, `head_key` is still the full key, and removing or suspending any entry leaves the full keys of the later entries unchanged. This holds for keys up to 2^KEY_W-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be accepted this cycle |
| cmd_op | input | 2 | 0 insert, 1 remove, 2 suspend, 3 resume |
| cmd_handle | input | HANDLE_W | External task handle |
| cmd_key | input | KEY_W | Ordering key for insert (smaller runs first) |
| busy | output | 1 | A list walk is in progress |
| err | output | 1 | Latest accepted command was rejected |
| head_valid | output | 1 | Queue holds at least one task |
| head_handle | output | HANDLE_W | Handle of the next task to run |
| head_key | output | KEY_W | Full key of the next task to run |

## Verification
A corrupted link or a mis-accumulated delta does not show at the ports until the faulty entry reaches the head. The bench therefore drains the queue one remove at a time and compares every head handle and full key against a sorted order worked out by hand. A bad slot binding shows one command later, as a wrong `err` or an untouched head. A walk that never finds its place or target leaves `busy` high, which the bounded-walk check reports within MAX_TASKS+2 cycles.

// File: rtl/rq_pkg.sv
package rq_pkg;
    typedef enum logic [1:0] {
        OP_INSERT  = 2'd0,
        OP_REMOVE  = 2'd1,
        OP_SUSPEND = 2'd2,
        OP_RESUME  = 2'd3
    } rq_op_e;

    typedef enum logic [1:0] {
        SLOT_FREE   = 2'd0,
        SLOT_QUEUED = 2'd1,
        SLOT_PARKED = 2'd2
    } slot_st_e;

    typedef enum logic [1:0] {
        FSM_IDLE   = 2'd0,
        FSM_PLACE  = 2'd1,
        FSM_UNLINK = 2'd2
    } fsm_e;
endpackage

// File: rtl/rq_handle_map.sv
module rq_handle_map #(
    parameter int N        = 8,
    parameter int HANDLE_W = 32,
    parameter int IW       = 3
) (
    input  logic [N-1:0][HANDLE_W-1:0] handles,
    input  logic [N-1:0]               used,
    input  logic [HANDLE_W-1:0]        probe,
    output logic                       hit,
    output logic [IW-1:0]              hit_slot,
    output logic                       has_free,
    output logic [IW-1:0]              free_slot
);
    logic [N-1:0] match;

    // one comparator per slot, only the binding table is searched in parallel
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign match[g] = used[g] && (handles[g] == probe);
    end

    always_comb begin
        hit       = 1'b0;
        hit_slot  = '0;
        has_free  = 1'b0;
        free_slot = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit      = 1'b1;
                hit_slot = IW'(i);
            end
            if (!used[i]) begin
                has_free  = 1'b1;
                free_slot = IW'(i);
            end
        end
    end
endmodule

// File: rtl/rq_key_step.sv
module rq_key_step #(
    parameter int KEY_W    = 16,
    parameter bit RELATIVE = 1'b1
) (
    input  logic [KEY_W-1:0] acc,
    input  logic [KEY_W-1:0] stored,
    input  logic [KEY_W-1:0] target,
    input  logic [KEY_W-1:0] succ_stored,
    output logic [KEY_W-1:0] cand,
    output logic             pass,
    output logic [KEY_W-1:0] place_key,
    output logic [KEY_W-1:0] succ_key,
    output logic [KEY_W-1:0] merged
);
    if (RELATIVE) begin : g_rel
        assign cand      = acc + stored;
        assign place_key = target - acc;
        assign succ_key  = cand - target;
        assign merged    = succ_stored + stored;
    end else begin : g_abs
        assign cand      = stored;
        assign place_key = target;
        assign succ_key  = stored;
        assign merged    = succ_stored;
    end

    // ties pass, so a new entry lands behind equal keys
    assign pass = (cand <= target);
endmodule

// File: rtl/rq_sched.sv
module rq_sched
    import rq_pkg::*;
#(
    parameter int MAX_TASKS     = 8,
    parameter int HANDLE_W      = 32,
    parameter int KEY_W         = 16,
    parameter bit RELATIVE_KEYS = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_valid,
    output logic                cmd_ready,
    input  logic [1:0]          cmd_op,
    input  logic [HANDLE_W-1:0] cmd_handle,
    input  logic [KEY_W-1:0]    cmd_key,
    output logic                busy,
    output logic                err,
    output logic                head_valid,
    output logic [HANDLE_W-1:0] head_handle,
    output logic [KEY_W-1:0]    head_key
);
    localparam int IW = (MAX_TASKS > 1) ? $clog2(MAX_TASKS) : 1;
    localparam int PW = $clog2(MAX_TASKS + 1);
    localparam logic [PW-1:0] NIL = PW'(MAX_TASKS);
    localparam int CW = $clog2(MAX_TASKS + 3) + 1;

    typedef struct packed {
        logic [MAX_TASKS-1:0][HANDLE_W-1:0] hdl;
        logic [MAX_TASKS-1:0][1:0]          st;
        logic [MAX_TASKS-1:0][KEY_W-1:0]    key;
        logic [MAX_TASKS-1:0][PW-1:0]       nxt;
        logic [PW-1:0]                      head;
        logic [1:0]                         fsm;
        logic [PW-1:0]                      cur;
        logic [PW-1:0]                      prev;
        logic [KEY_W-1:0]                   acc;
        logic [IW-1:0]                      tslot;
        logic [KEY_W-1:0]                   tkey;
        logic                               del_free;
        logic                               err;
    } regs_t;

    regs_t r_q, r_d;

    logic [MAX_TASKS-1:0] used;
    logic                 hit, has_free;
    logic [IW-1:0]        hit_slot, free_slot;
    logic [IW-1:0]        ci, pi, si, hi;
    logic [PW-1:0]        succ;
    logic [KEY_W-1:0]     cand, place_key, succ_key, merged;
    logic                 pass;
    logic                 cmd_fire;

    for (genvar g = 0; g < MAX_TASKS; g++) begin : g_used
        assign used[g] = (r_q.st[g] != SLOT_FREE);
    end

    rq_handle_map #(.N(MAX_TASKS), .HANDLE_W(HANDLE_W), .IW(IW)) u_map (
        .handles  (r_q.hdl),
        .used     (used),
        .probe    (cmd_handle),
        .hit      (hit),
        .hit_slot (hit_slot),
        .has_free (has_free),
        .free_slot(free_slot)
    );

    assign ci   = r_q.cur[IW-1:0];
    assign pi   = r_q.prev[IW-1:0];
    assign succ = r_q.nxt[ci];
    assign si   = succ[IW-1:0];
    assign hi   = r_q.head[IW-1:0];

    rq_key_step #(.KEY_W(KEY_W), .RELATIVE(RELATIVE_KEYS)) u_step (
        .acc        (r_q.acc),
        .stored     (r_q.key[ci]),
        .target     (r_q.tkey),
        .succ_stored(r_q.key[si]),
        .cand       (cand),
        .pass       (pass),
        .place_key  (place_key),
        .succ_key   (succ_key),
        .merged     (merged)
    );

    assign busy     = (r_q.fsm != FSM_IDLE);
    assign cmd_ready = !busy;
    assign cmd_fire = cmd_valid && !busy;

    always_comb begin
        r_d = r_q;
        unique case (r_q.fsm)
            FSM_IDLE: begin
                if (cmd_valid) begin
                    r_d.err  = 1'b0;
                    r_d.cur  = r_q.head;
                    r_d.prev = NIL;
                    r_d.acc  = '0;
                    unique case (cmd_op)
                        OP_INSERT: begin
                            if (hit || !has_free) begin
                                r_d.err = 1'b1;
                            end else begin
                                r_d.hdl[free_slot] = cmd_handle;
                                r_d.tslot = free_slot;
                                r_d.tkey  = cmd_key;
                                r_d.fsm   = FSM_PLACE;
                            end
                        end
                        OP_REMOVE: begin
                            if (!hit) begin
                                r_d.err = 1'b1;
                            end else if (r_q.st[hit_slot] == SLOT_PARKED) begin
                                r_d.st[hit_slot] = SLOT_FREE;
                            end else begin
                                r_d.tslot    = hit_slot;
                                r_d.del_free = 1'b1;
                                r_d.fsm      = FSM_UNLINK;
                            end
                        end
                        OP_SUSPEND: begin
                            if (!hit) begin
                                r_d.err = 1'b1;
                            end else if (r_q.st[hit_slot] == SLOT_QUEUED) begin
                                r_d.tslot    = hit_slot;
                                r_d.del_free = 1'b0;
                                r_d.fsm      = FSM_UNLINK;
                            end
                        end
                        default: begin
                            if (!hit) begin
                                r_d.err = 1'b1;
                            end else if (r_q.st[hit_slot] == SLOT_PARKED) begin
                                r_d.tslot = hit_slot;
                                r_d.tkey  = r_q.key[hit_slot];
                                r_d.fsm   = FSM_PLACE;
                            end
                        end
                    endcase
                end
            end
            FSM_PLACE: begin
                if (r_q.cur != NIL && pass) begin
                    r_d.prev = r_q.cur;
                    r_d.acc  = cand;
                    r_d.cur  = r_q.nxt[ci];
                end else begin
                    r_d.key[r_q.tslot] = place_key;
                    r_d.nxt[r_q.tslot] = r_q.cur;
                    if (r_q.cur != NIL) begin
                        r_d.key[ci] = succ_key;
                    end
                    if (r_q.prev == NIL) begin
                        r_d.head = PW'(r_q.tslot);
                    end else begin
                        r_d.nxt[pi] = PW'(r_q.tslot);
                    end
                    r_d.st[r_q.tslot] = SLOT_QUEUED;
                    r_d.fsm = FSM_IDLE;
                end
            end
            FSM_UNLINK: begin
                if (r_q.cur != PW'(r_q.tslot)) begin
                    r_d.prev = r_q.cur;
                    r_d.acc  = cand;
                    r_d.cur  = r_q.nxt[ci];
                end else begin
                    if (r_q.prev == NIL) begin
                        r_d.head = succ;
                    end else begin
                        r_d.nxt[pi] = succ;
                    end
                    if (succ != NIL) begin
                        r_d.key[si] = merged;
                    end
                    if (r_q.del_free) begin
                        r_d.st[r_q.tslot] = SLOT_FREE;
                    end else begin
                        r_d.st[r_q.tslot]  = SLOT_PARKED;
                        r_d.key[r_q.tslot] = cand;
                    end
                    r_d.fsm = FSM_IDLE;
                end
            end
            default: r_d.fsm = FSM_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.head <= NIL;
            r_q.cur  <= NIL;
            r_q.prev <= NIL;
        end else begin
            r_q <= r_d;
        end
    end

    assign err         = r_q.err;
    assign head_valid  = (r_q.head != NIL);
    assign head_handle = head_valid ? r_q.hdl[hi] : '0;
    assign head_key    = head_valid ? r_q.key[hi] : '0;

    // length of the current run of busy cycles, used to bound a walk
    logic [CW-1:0] busy_run;
    always_ff @(posedge clk) begin
        if (!rst_n) busy_run <= '0;
        else if (busy) busy_run <= busy_run + 1'b1;
        else busy_run <= '0;
    end

    AST_WALK_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        busy_run <= CW'(MAX_TASKS + 1)); // R9

    AST_HEAD_IS_QUEUED: assert property (@(posedge clk) disable iff (!rst_n)
        head_valid |-> (r_q.st[hi] == SLOT_QUEUED)); // R5

    AST_FULL_INSERT_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_fire && cmd_op == OP_INSERT && !hit && !has_free) |=> err); // R7

    AST_UNBOUND_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_fire && cmd_op != OP_INSERT && !hit) |=> (err && !busy)); // R6

    AST_HEAD_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !cmd_fire) |=> ($stable(head_handle) && $stable(head_key))); // R8
endmodule

// File: tb/sim_rq_sched.sv
module sim_rq_sched;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cmd_valid;
    logic        cmd_ready;
    logic [1:0]  cmd_op;
    logic [31:0] cmd_handle;
    logic [15:0] cmd_key;
    logic        busy, err, head_valid;
    logic [31:0] head_handle;
    logic [15:0] head_key;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    rq_sched u0 (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
        .cmd_handle(cmd_handle), .cmd_key(cmd_key),
        .busy(busy), .err(err), .head_valid(head_valid),
        .head_handle(head_handle), .head_key(head_key)
    );

    typedef struct packed {
        logic [1:0]  op;
        logic [31:0] hnd;
        logic [15:0] key;
        logic        e_err;
        logic        e_hv;
        logic [31:0] e_hh;
        logic [15:0] e_hk;
    } vec_t;

    localparam logic [31:0] A1 = 32'h1000_00A1, A2 = 32'h2000_00A2, A3 = 32'h3000_00A3;
    localparam logic [31:0] A4 = 32'h4000_00A4, A5 = 32'h5000_00A5, XX = 32'hDEAD_BEEF;

    localparam vec_t VECS [16] = '{
        '{2'd0, A1, 16'd50, 1'b0, 1'b1, A1, 16'd50},   // R2
        '{2'd0, A2, 16'd20, 1'b0, 1'b1, A2, 16'd20},   // R2
        '{2'd0, A3, 16'd20, 1'b0, 1'b1, A2, 16'd20},   // R3
        '{2'd0, A4, 16'd80, 1'b0, 1'b1, A2, 16'd20},   // R2
        '{2'd1, A2, 16'd0,  1'b0, 1'b1, A3, 16'd20},   // R4
        '{2'd2, A3, 16'd0,  1'b0, 1'b1, A1, 16'd50},   // R5
        '{2'd2, A3, 16'd0,  1'b0, 1'b1, A1, 16'd50},   // R10
        '{2'd3, A1, 16'd0,  1'b0, 1'b1, A1, 16'd50},   // R10
        '{2'd1, XX, 16'd0,  1'b1, 1'b1, A1, 16'd50},   // R6
        '{2'd0, A5, 16'd50, 1'b0, 1'b1, A1, 16'd50},   // R8
        '{2'd3, A3, 16'd0,  1'b0, 1'b1, A3, 16'd20},   // R5
        '{2'd1, A3, 16'd0,  1'b0, 1'b1, A1, 16'd50},   // R11
        '{2'd1, A1, 16'd0,  1'b0, 1'b1, A5, 16'd50},   // R3
        '{2'd0, A4, 16'd5,  1'b1, 1'b1, A5, 16'd50},   // R6
        '{2'd1, A5, 16'd0,  1'b0, 1'b1, A4, 16'd80},   // R11
        '{2'd1, A4, 16'd0,  1'b0, 1'b0, 32'd0, 16'd0}  // R4
    };

    string tags [16] = '{"R2", "R2", "R3", "R2", "R4", "R5", "R10", "R10",
                         "R6", "R8", "R5", "R11", "R3", "R6", "R11", "R4"};

    task automatic report();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // drive at the falling edge, accepted at the next rising edge
    task automatic issue(input logic [1:0] op, input logic [31:0] h, input logic [15:0] k);
        @(negedge clk);
        cmd_valid  = 1'b1;
        cmd_op     = op;
        cmd_handle = h;
        cmd_key    = k;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic run(input logic [1:0] op, input logic [31:0] h, input logic [15:0] k);
        issue(op, h, k);
        wait_idle();
    endtask

    logic [31:0] fh [8];
    logic [15:0] fk [8];
    logic [31:0] oh [8];
    logic [15:0] ok [8];

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        report();
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        cmd_valid = 1'b0;
        cmd_op = 2'd0;
        cmd_handle = '0;
        cmd_key = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1", {31'd0, head_valid}, 32'd0);
        chk("R1", {31'd0, busy}, 32'd0);
        chk("R1", {31'd0, err}, 32'd0);
        chk("R1", {31'd0, cmd_ready}, 32'd1);

        for (int i = 0; i < 16; i++) begin
            run(VECS[i].op, VECS[i].hnd, VECS[i].key);
            chk(tags[i], {31'd0, err}, {31'd0, VECS[i].e_err});
            chk(tags[i], {31'd0, head_valid}, {31'd0, VECS[i].e_hv});
            if (VECS[i].e_hv) begin
                chk(tags[i], head_handle, VECS[i].e_hh);
                chk(tags[i], {16'd0, head_key}, {16'd0, VECS[i].e_hk});
            end
        end

        // fill every slot; keys include both extremes and ties
        fh = '{32'hB000_0000, 32'hB000_0001, 32'hB000_0002, 32'hB000_0003,
               32'hB000_0004, 32'hB000_0005, 32'hB000_0006, 32'hB000_0007};
        fk = '{16'd65535, 16'd100, 16'd30000, 16'd100, 16'd0, 16'd65534, 16'd7, 16'd30000};
        for (int i = 0; i < 8; i++) begin
            issue(2'd0, fh[i], fk[i]);
            if (i == 0) begin
                // R9: the walk holds busy and drops ready after acceptance
                chk("R9", {31'd0, busy}, 32'd1);
                chk("R9", {31'd0, cmd_ready}, 32'd0);
            end
            wait_idle();
        end
        chk("R2", head_handle, fh[4]);
        chk("R11", {16'd0, head_key}, 32'd0);

        run(2'd2, fh[2], 16'd0);                   // R5 park one entry
        run(2'd0, 32'hB000_0008, 16'd1);           // R7 parked slot still counts
        chk("R7", {31'd0, err}, 32'd1);
        chk("R7", head_handle, fh[4]);
        run(2'd3, fh[2], 16'd0);                   // R5 resume behind the equal key
        chk("R8", {31'd0, err}, 32'd0);

        // expected drain order: ascending keys, ties in arrival order
        oh = '{fh[4], fh[6], fh[1], fh[3], fh[7], fh[2], fh[5], fh[0]};
        ok = '{16'd0, 16'd7, 16'd100, 16'd100, 16'd30000, 16'd30000, 16'd65534, 16'd65535};
        for (int i = 0; i < 8; i++) begin
            chk("R3", head_handle, oh[i]);
            chk("R11", {16'd0, head_key}, {16'd0, ok[i]});
            run(2'd1, head_handle, 16'd0);
        end
        chk("R4", {31'd0, head_valid}, 32'd0);

        // R4: a released handle binds again
        run(2'd0, fh[0], 16'd3);
        chk("R4", {31'd0, err}, 32'd0);
        chk("R4", head_handle, fh[0]);
        chk("R4", {16'd0, head_key}, 32'd3);

        // R6: suspend of an unbound handle leaves the head as it was
        run(2'd2, XX, 16'd0);
        chk("R6", {31'd0, err}, 32'd1);
        chk("R6", head_handle, fh[0]);

        report();
        $finish;
    end
endmodule